// File: doc/BRIEF.md
# Byte-Serial Master with Chip-Select Sequencing

This block moves 8-bit frames over a four-wire serial bus as the bus master. A host writes a byte and a last-frame tag into a one-entry transmit holding register. It reads each received byte from a receive register that has full and overrun flags. The engine generates the serial clock from the system clock and shifts data out most significant bit first. It samples the input line on the clock edge that the configuration selects. It also drives an active-low select line.

The select line is sequenced by timing controls: a pre-clock delay, a gap between frames and a minimum select-inactive time. With the hold option set, select stays active across back-to-back frames. It is released only after a frame tagged as last. Command-then-response exchanges with a peripheral can therefore run under a single select window. Each frame sent also returns exactly one frame. A loopback option routes the outgoing bit stream straight into the receiver, for self-test without a peripheral.

Top module: `spi_seq_master`

## Requirements
- R1: After reset `cs_n` is 1, `sck` equals `cfg_cpol`, `tx_ready` and `tx_empty` are 1, and `rx_full` and `overrun` are 0.
- R2: While a frame shifts, the period of `sck` is `cfg_div` system clocks (values below 2 act as 2). The half before each leading edge lasts floor(div/2) clocks and the rest of the period follows it. When select is inactive, `sck` rests at `cfg_cpol`.
- R3: Frames are 8 bits and go out on `mosi` most significant bit first. The received byte is assembled in the same order.
- R4: With `cfg_cap_lead`=1 the input is sampled on each leading edge (the edge away from `cfg_cpol`) and `mosi` changes on trailing edges. With 0 the input is sampled on trailing edges and `mosi` changes on leading edges.
- R5: The first leading edge follows the fall of `cs_n` by `cfg_pre_dly` clocks. When that field is 0 the wait is floor(div/2) clocks.
- R6: With select held and the next byte already waiting, a zero `cfg_xfer_gap` makes the next frame's first leading edge follow the last trailing edge by floor(div/2) clocks, so the clock period stays even across the boundary. A nonzero gap adds at least `cfg_xfer_gap` clocks before the pre-clock delay.
- R7: `cs_n` stays high for at least `cfg_cs_gap` clocks between a release and the next assertion.
- R8: With `cfg_hold`=1 select stays low after a frame until a frame written with `wr_last`=1 completes. With `cfg_hold`=0 select is released after every frame.
- R9: A write is accepted only while `tx_ready`=1; a write while `tx_ready`=0 leaves the pending byte unchanged. A frame starts only while `enable`=1.
- R10: `tx_empty` is 1 only when the holding register is empty and no frame is in progress.
- R11: Each completed frame loads `rd_data` and sets `rx_full`. A one-cycle `rd_en` pulse clears `rx_full` and `overrun`.
- R12: `overrun` is set when a frame completes while `rx_full` is still 1, and `rd_data` then shows the newest byte.
- R13: With `cfg_loop`=1 the received byte equals the sent byte and `miso` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows new frames to start |
| cfg_div | input | 8 | Serial clock divisor |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cap_lead | input | 1 | 1: sample on leading edge; 0: sample on trailing edge |
| cfg_pre_dly | input | 8 | Clocks from select assertion to first edge (0 = half period) |
| cfg_xfer_gap | input | 8 | Extra clocks between frames |
| cfg_cs_gap | input | 8 | Minimum select-inactive clocks |
| cfg_hold | input | 1 | Keep select active until a last-tagged frame |
| cfg_loop | input | 1 | Internal loopback of output to input |
| wr_en | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 8 | Byte to send |
| wr_last | input | 1 | Tags the byte as the last of a select window |
| tx_ready | output | 1 | Holding register can take a byte |
| tx_empty | output | 1 | Holding register and shifter both empty |
| rd_en | input | 1 | Read strobe for the receive register |
| rd_data | output | 8 | Last received byte |
| rx_full | output | 1 | Unread byte present |
| overrun | output | 1 | A byte arrived while the previous one was unread |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select |

## Verification
Several properties are checked on every cycle. The clock rests at its idle level whenever select is inactive. Select is asserted only after the inactive-time minimum has passed, and it is released only after a last-tagged frame or with hold off. The completion strobe is a single pulse, a pending byte cannot be overwritten, and overrun rises only on top of a full receive register. Select stays inactive while the block is disabled. Exact edge timing can only be shown by the bench scenarios: the clock period, the pre-clock delay, seamless chaining across frames and the extra gap. The scenarios also show bit order, capture-edge selection, loopback, and the data returned by a peripheral model.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL,
        ST_GAP
    } eng_state_e;
endpackage

// File: rtl/spi_seq_bufs.sv
module spi_seq_bufs #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_data,
    input  logic               wr_last,
    input  logic               take,
    input  logic               rd_en,
    input  logic               done,
    input  logic [FRAME_W-1:0] rx_byte,
    output logic               hold_valid,
    output logic [FRAME_W-1:0] hold_data,
    output logic               hold_last,
    output logic [FRAME_W-1:0] rd_data,
    output logic               rx_full,
    output logic               overrun
);
    typedef struct packed {
        logic               valid;
        logic [FRAME_W-1:0] data;
        logic               last;
        logic [FRAME_W-1:0] rxd;
        logic               full;
        logic               ovr;
    } buf_t;

    buf_t q, d;

    always_comb begin
        d = q;
        if (take) begin
            d.valid = 1'b0;
        end
        if (wr_en && !q.valid) begin
            d.valid = 1'b1;
            d.data  = wr_data;
            d.last  = wr_last;
        end
        if (rd_en) begin
            d.full = 1'b0;
            d.ovr  = 1'b0;
        end
        if (done) begin
            d.rxd  = rx_byte;
            d.full = 1'b1;
            if (q.full && !rd_en) begin
                d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign hold_valid = q.valid;
    assign hold_data  = q.data;
    assign hold_last  = q.last;
    assign rd_data    = q.rxd;
    assign rx_full    = q.full;
    assign overrun    = q.ovr;

    // R9: a pending byte is never replaced before the engine takes it
    a_r9_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (q.valid && !take) |=> (q.data == $past(q.data)));

    // R12: overrun only on top of an unread byte
    a_r12_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovr) |-> $past(q.full));

    // R11: a read with no new arrival empties the receive register
    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !done) |=> (!q.full && !q.ovr));
endmodule

// File: rtl/spi_seq_engine.sv
module spi_seq_engine
    import spi_seq_pkg::*;
#(
    parameter int FRAME_W = 8,
    parameter int DIV_W   = 8,
    parameter int DLY_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic               cfg_cap_lead,
    input  logic [DLY_W-1:0]   cfg_pre_dly,
    input  logic [DLY_W-1:0]   cfg_xfer_gap,
    input  logic [DLY_W-1:0]   cfg_cs_gap,
    input  logic               cfg_hold,
    input  logic               hold_valid,
    input  logic [FRAME_W-1:0] hold_data,
    input  logic               hold_last,
    input  logic               sin,
    output logic               take,
    output logic               sck_lvl,
    output logic               cs_act,
    output logic               sout,
    output logic               done,
    output logic [FRAME_W-1:0] rx_byte,
    output logic               busy
);
    localparam int CNT_W = ((DIV_W > DLY_W) ? DIV_W : DLY_W) + 1;
    localparam int BIT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO  = CNT_W'(2);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

    typedef struct packed {
        eng_state_e         st;
        logic               cs_act;
        logic               sck_lvl;
        logic [CNT_W-1:0]   cnt;
        logic [BIT_W-1:0]   bits;
        logic [FRAME_W-1:0] tx_sh;
        logic [FRAME_W-1:0] rx_sh;
        logic               last;
        logic [DLY_W-1:0]   idle_cnt;
        logic               done;
    } eng_t;

    eng_t q, d;

    logic [CNT_W-1:0] div_raw, div_eff, h_lo, h_hi, lead_len, gap_len;
    logic             lead_edge, trail_edge, do_load, release_cs;

    always_comb begin
        div_raw  = {{(CNT_W-DIV_W){1'b0}}, cfg_div};
        div_eff  = (div_raw < TWO) ? TWO : div_raw;
        h_lo     = div_eff >> 1;
        h_hi     = div_eff - h_lo;
        lead_len = (cfg_pre_dly == '0) ? h_lo : {{(CNT_W-DLY_W){1'b0}}, cfg_pre_dly};
        gap_len  = {{(CNT_W-DLY_W){1'b0}}, cfg_xfer_gap};
    end

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        lead_edge  = 1'b0;
        trail_edge = 1'b0;
        do_load    = 1'b0;
        release_cs = q.last || !cfg_hold;

        if (!q.cs_act && (q.idle_cnt != '1)) begin
            d.idle_cnt = q.idle_cnt + 1'b1;
        end

        case (q.st)
            ST_IDLE: begin
                if (enable && hold_valid) begin
                    if (q.cs_act) begin
                        do_load = 1'b1;
                    end else if (q.idle_cnt >= cfg_cs_gap) begin
                        do_load  = 1'b1;
                        d.cs_act = 1'b1;
                    end
                end
            end
            ST_LEAD: begin
                if (q.cnt == lead_len - ONE) begin
                    d.cnt     = '0;
                    d.st      = ST_SHIFT;
                    d.sck_lvl = 1'b1;
                    lead_edge = 1'b1;
                end else begin
                    d.cnt = q.cnt + ONE;
                end
            end
            ST_SHIFT: begin
                if (q.sck_lvl) begin
                    if (q.cnt == h_hi - ONE) begin
                        d.cnt      = '0;
                        d.sck_lvl  = 1'b0;
                        trail_edge = 1'b1;
                    end else begin
                        d.cnt = q.cnt + ONE;
                    end
                end else begin
                    if (q.cnt == h_lo - ONE) begin
                        d.cnt     = '0;
                        d.sck_lvl = 1'b1;
                        lead_edge = 1'b1;
                    end else begin
                        d.cnt = q.cnt + ONE;
                    end
                end
            end
            ST_TAIL: begin
                if (q.cnt == h_lo - ONE) begin
                    d.cnt      = '0;
                    d.cs_act   = 1'b0;
                    d.idle_cnt = '0;
                    d.st       = (cfg_xfer_gap == '0) ? ST_IDLE : ST_GAP;
                end else begin
                    d.cnt = q.cnt + ONE;
                end
            end
            ST_GAP: begin
                if (q.cnt == gap_len - ONE) begin
                    d.cnt = '0;
                    d.st  = ST_IDLE;
                end else begin
                    d.cnt = q.cnt + ONE;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (lead_edge) begin
            if (cfg_cap_lead) begin
                d.rx_sh = {q.rx_sh[FRAME_W-2:0], sin};
            end else if (q.bits != '0) begin
                d.tx_sh = q.tx_sh << 1;
            end
        end

        if (trail_edge) begin
            if (cfg_cap_lead) begin
                d.tx_sh = q.tx_sh << 1;
            end else begin
                d.rx_sh = {q.rx_sh[FRAME_W-2:0], sin};
            end
            d.bits = q.bits + 1'b1;
            if (q.bits == LAST_BIT) begin
                d.done = 1'b1;
                d.bits = '0;
                d.cnt  = '0;
                if (release_cs) begin
                    d.st = ST_TAIL;
                end else if (cfg_xfer_gap != '0) begin
                    d.st = ST_GAP;
                end else if (enable && hold_valid) begin
                    do_load = 1'b1;
                end else begin
                    d.st = ST_IDLE;
                end
            end
        end

        if (do_load) begin
            d.tx_sh = hold_data;
            d.last  = hold_last;
            d.st    = ST_LEAD;
            d.cnt   = '0;
            d.bits  = '0;
        end
        take = do_load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
            q.idle_cnt <= '1;
        end else begin
            q <= d;
        end
    end

    assign sck_lvl = q.sck_lvl;
    assign cs_act  = q.cs_act;
    assign sout    = q.tx_sh[FRAME_W-1];
    assign done    = q.done;
    assign rx_byte = q.rx_sh;
    assign busy    = (q.st != ST_IDLE);

    // R2: the clock is parked whenever select is inactive
    a_r2_sck_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !q.cs_act |-> !q.sck_lvl);

    // R7: select asserts only after the inactive minimum has elapsed
    a_r7_cs_gap_met: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.cs_act) |-> ($past(q.idle_cnt) >= $past(cfg_cs_gap)));

    // R8: select falls away only after a last-tagged frame or with hold off
    a_r8_release_rule: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.cs_act) |-> ($past(q.last) || !$past(cfg_hold)));

    // R11: one completion strobe per frame
    a_r11_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
endmodule

// File: rtl/spi_seq_master.sv
module spi_seq_master #(
    parameter int FRAME_W = 8,
    parameter int DIV_W   = 8,
    parameter int DLY_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic               cfg_cpol,
    input  logic               cfg_cap_lead,
    input  logic [DLY_W-1:0]   cfg_pre_dly,
    input  logic [DLY_W-1:0]   cfg_xfer_gap,
    input  logic [DLY_W-1:0]   cfg_cs_gap,
    input  logic               cfg_hold,
    input  logic               cfg_loop,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_data,
    input  logic               wr_last,
    output logic               tx_ready,
    output logic               tx_empty,
    input  logic               rd_en,
    output logic [FRAME_W-1:0] rd_data,
    output logic               rx_full,
    output logic               overrun,
    output logic               sck,
    output logic               mosi,
    input  logic               miso,
    output logic               cs_n
);
    logic               hold_valid, hold_last, take, done, busy;
    logic               sck_lvl, cs_act, sout, sin;
    logic [FRAME_W-1:0] hold_data, rx_byte;

    assign sin = cfg_loop ? sout : miso;

    spi_seq_bufs #(.FRAME_W(FRAME_W)) bufs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_last    (wr_last),
        .take       (take),
        .rd_en      (rd_en),
        .done       (done),
        .rx_byte    (rx_byte),
        .hold_valid (hold_valid),
        .hold_data  (hold_data),
        .hold_last  (hold_last),
        .rd_data    (rd_data),
        .rx_full    (rx_full),
        .overrun    (overrun)
    );

    spi_seq_engine #(.FRAME_W(FRAME_W), .DIV_W(DIV_W), .DLY_W(DLY_W)) eng_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .cfg_div      (cfg_div),
        .cfg_cap_lead (cfg_cap_lead),
        .cfg_pre_dly  (cfg_pre_dly),
        .cfg_xfer_gap (cfg_xfer_gap),
        .cfg_cs_gap   (cfg_cs_gap),
        .cfg_hold     (cfg_hold),
        .hold_valid   (hold_valid),
        .hold_data    (hold_data),
        .hold_last    (hold_last),
        .sin          (sin),
        .take         (take),
        .sck_lvl      (sck_lvl),
        .cs_act       (cs_act),
        .sout         (sout),
        .done         (done),
        .rx_byte      (rx_byte),
        .busy         (busy)
    );

    assign tx_ready = ~hold_valid;
    assign tx_empty = ~hold_valid & ~busy;
    assign sck      = sck_lvl ^ cfg_cpol;
    assign mosi     = sout;
    assign cs_n     = ~cs_act;

    // R9: no select window opens while disabled
    a_r9_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && cs_n) |=> cs_n);
endmodule

// File: tb/spi_seq_master_tb_top.sv
`timescale 1ns/1ps
module spi_seq_master_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] cfg_div = 8'd4;
    logic       cfg_cpol = 1'b0;
    logic       cfg_cap_lead = 1'b1;
    logic [7:0] cfg_pre_dly = 8'd0;
    logic [7:0] cfg_xfer_gap = 8'd0;
    logic [7:0] cfg_cs_gap = 8'd0;
    logic       cfg_hold = 1'b0;
    logic       cfg_loop = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       wr_last = 1'b0;
    logic       rd_en = 1'b0;
    logic       tx_ready, tx_empty, rx_full, overrun, sck, mosi, miso, cs_n;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_seq_master dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_div(cfg_div),
        .cfg_cpol(cfg_cpol), .cfg_cap_lead(cfg_cap_lead), .cfg_pre_dly(cfg_pre_dly),
        .cfg_xfer_gap(cfg_xfer_gap), .cfg_cs_gap(cfg_cs_gap), .cfg_hold(cfg_hold),
        .cfg_loop(cfg_loop), .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
        .tx_ready(tx_ready), .tx_empty(tx_empty), .rd_en(rd_en), .rd_data(rd_data),
        .rx_full(rx_full), .overrun(overrun), .sck(sck), .mosi(mosi), .miso(miso),
        .cs_n(cs_n)
    );

    // bus monitor and peripheral model, evaluated on falling clock edges
    logic       sck_prev = 1'b0, cs_prev = 1'b1;
    logic [7:0] s_pat = 8'h00, s_sh = 8'h00, mon_byte = 8'h00;
    logic       s_first = 1'b0;
    int t_cs_fall = 0, t_cs_rise = 0, t_lead = 0, t_trail = 0;
    int first_dly = -1, per_min = 0, per_max = 0, gap_min = 0, gap_tl_max = 0, cs_rises = 0;
    bit first_seen = 0, lead_valid = 0, trail_valid = 0, rise_seen = 0;

    assign miso = s_sh[7];

    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n !== cs_prev) begin
                if (!cs_n) begin
                    t_cs_fall = cyc; first_seen = 0; lead_valid = 0; trail_valid = 0;
                    s_sh = s_pat; s_first = 1;
                    if (rise_seen && (cyc - t_cs_rise) < gap_min) gap_min = cyc - t_cs_rise;
                end else begin
                    t_cs_rise = cyc; rise_seen = 1; cs_rises++;
                end
            end
            if (sck !== sck_prev && !cs_n) begin
                if (sck != cfg_cpol) begin
                    if (!first_seen) begin first_dly = cyc - t_cs_fall; first_seen = 1; end
                    if (lead_valid) begin
                        if (cyc - t_lead < per_min) per_min = cyc - t_lead;
                        if (cyc - t_lead > per_max) per_max = cyc - t_lead;
                    end
                    if (trail_valid && (cyc - t_trail) > gap_tl_max) gap_tl_max = cyc - t_trail;
                    t_lead = cyc; lead_valid = 1;
                    if (cfg_cap_lead) mon_byte = {mon_byte[6:0], mosi};
                    else if (s_first) s_first = 0;
                    else s_sh = s_sh << 1;
                end else begin
                    t_trail = cyc; trail_valid = 1;
                    if (cfg_cap_lead) s_sh = s_sh << 1;
                    else mon_byte = {mon_byte[6:0], mosi};
                end
            end
            sck_prev = sck; cs_prev = cs_n;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic clear_stats();
        per_min = 1000000; per_max = 0; gap_min = 1000000; gap_tl_max = 0;
        cs_rises = 0; mon_byte = 8'h00; first_dly = -1; rise_seen = 0;
    endtask

    task automatic send(input logic [7:0] b, input logic l);
        while (!tx_ready) @(negedge clk);
        wr_data = b; wr_last = l; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!tx_empty) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 cs_n", cs_n, 1);
        chk("R1 sck idle", sck, cfg_cpol);
        chk("R1 tx_ready", tx_ready, 1);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 overrun", overrun, 0);
    endtask

    task automatic t_basic_external();
        cfg_div = 4; cfg_cpol = 0; cfg_cap_lead = 1; cfg_pre_dly = 0; cfg_loop = 0;
        cfg_hold = 0; s_pat = 8'hA5; enable = 1;
        @(negedge clk); clear_stats();
        send(8'h3C, 1'b1);
        repeat (10) @(negedge clk);
        chk("R10 busy not empty", tx_empty, 0);
        wait_idle();
        chk("R3 msb-first out", mon_byte, 8'h3C);
        chk("R11 rx data from miso", rd_data, 8'hA5);
        chk("R11 rx_full set", rx_full, 1);
        chk("R5 half-period lead", first_dly, 2);
        chk("R2 period min", per_min, 4);
        chk("R2 period max", per_max, 4);
        chk("R8 released hold off", cs_n, 1);
        do_read();
        chk("R11 read clears", rx_full, 0);
    endtask

    task automatic t_loop_trailing();
        cfg_div = 5; cfg_cpol = 1; cfg_cap_lead = 0; cfg_pre_dly = 3; cfg_loop = 1;
        s_pat = 8'hFF;
        @(negedge clk); clear_stats();
        send(8'h96, 1'b1);
        wait_idle();
        chk("R13 loopback ignores miso", rd_data, 8'h96);
        chk("R4 trailing capture stream", mon_byte, 8'h96);
        chk("R5 programmed lead", first_dly, 3);
        chk("R2 odd divisor period", per_max, 5);
        chk("R2 idle at cpol", sck, 1);
        do_read();
        cfg_cpol = 0; cfg_pre_dly = 0; cfg_cap_lead = 1;
    endtask

    task automatic t_chain_overrun();
        cfg_div = 4; cfg_hold = 1; cfg_xfer_gap = 0; cfg_cs_gap = 0; cfg_loop = 1;
        @(negedge clk); clear_stats();
        send(8'h11, 1'b0);
        send(8'h22, 1'b0);
        send(8'h33, 1'b1);
        wait_idle();
        chk("R8 single window", cs_rises, 1);
        chk("R6 seamless period min", per_min, 4);
        chk("R6 seamless period max", per_max, 4);
        chk("R6 trail-to-lead", gap_tl_max, 2);
        chk("R12 overrun set", overrun, 1);
        chk("R12 newest byte", rd_data, 8'h33);
        do_read();
        chk("R11 overrun cleared", overrun, 0);
    endtask

    task automatic t_hold_open();
        cfg_hold = 1;
        @(negedge clk); clear_stats();
        send(8'h44, 1'b0);
        wait_idle();
        repeat (10) @(negedge clk);
        chk("R8 held open", cs_n, 0);
        send(8'h55, 1'b1);
        wait_idle();
        chk("R8 released after last", cs_n, 1);
        do_read();
    endtask

    task automatic t_xfer_gap();
        cfg_hold = 1; cfg_xfer_gap = 7;
        @(negedge clk); clear_stats();
        send(8'h61, 1'b0);
        send(8'h62, 1'b1);
        wait_idle();
        chk_range("R6 programmed gap", gap_tl_max, 9, 11);
        chk("R8 one window", cs_rises, 1);
        do_read();
        cfg_xfer_gap = 0;
    endtask

    task automatic t_cs_gap();
        cfg_hold = 0; cfg_cs_gap = 6; cfg_xfer_gap = 3;
        @(negedge clk); clear_stats();
        send(8'h01, 1'b0);
        send(8'h02, 1'b0);
        wait_idle();
        chk("R8 released each frame", cs_rises, 2);
        chk_range("R7 select gap", gap_min, 6, 8);
        do_read();
        cfg_cs_gap = 0; cfg_xfer_gap = 0;
    endtask

    task automatic t_disabled_and_full();
        enable = 0; cfg_loop = 1;
        @(negedge clk);
        send(8'h5A, 1'b1);
        chk("R9 ready drops", tx_ready, 0);
        repeat (20) @(negedge clk);
        chk("R9 no start disabled", cs_n, 1);
        chk("R10 pending not empty", tx_empty, 0);
        wr_data = 8'hC3; wr_last = 1; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
        enable = 1;
        wait_idle();
        chk("R9 ignored write", rd_data, 8'h5A);
        chk("R10 empty after", tx_empty, 1);
        do_read();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic_external();
        t_loop_trailing();
        t_chain_overrun();
        t_hold_open();
        t_xfer_gap();
        t_cs_gap();
        t_disabled_and_full();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule